// File: doc/BRIEF.md
# Two-Word Array Element Access Sequencer

This block carries out loads and stores of 64-bit array elements held in a memory that is only 32 bits wide. A command brings an array reference, an element index and, for a store, the 64-bit value. The sequencer rejects a zero reference at once. For any other reference it reads the array length from the word just above the reference and tests the index against that length. It then reads the handle word at the reference to find where the element data lives, and moves the element as two 32-bit memory transactions.

The command side uses a ready/valid handshake and accepts one command at a time. Each command finishes with a one-cycle done pulse. The pulse carries a status code and, for a successful load, the assembled 64-bit value. The memory side keeps at most one transaction in flight. Memory reports progress on a busy flag that only rises the cycle after a request has been sampled. The sequencer therefore never trusts busy in that first cycle.

Top module: `wide_elem_seq`

## Requirements
- R1: A command whose reference is zero completes with status 1 (null) on `rsp_done` in the cycle after acceptance, and it issues no memory transaction of any kind.
- R2: For a non-zero reference, the first memory transaction is a read at address reference+1, which returns the array length.
- R3: The index is out of range when bit 31 of ((length - 1 - index) OR index) is 1. This covers a negative index and any index equal to or above the length. Such a command completes with status 2 (bounds), and the length read is its only memory transaction.
- R4: When the index is in range, the second transaction is a read at the reference address itself, and the word it returns is the element base address.
- R5: The two element transactions use addresses base + 2*index and then base + 2*index + 1, with 32-bit wrap-around.
- R6: A store writes bits 31:0 of the value to the first element address and bits 63:32 to the second. It then completes with status 0.
- R7: A load reads the first element word before the second and completes with status 0. The returned `rsp_rdata` is {second word, first word}.
- R8: A new memory request is issued only after the previous one has finished. The sequencer treats busy as meaningful only from the second cycle after a request is sampled, and it takes read data only when busy is low in that window. The strobes are one cycle long and never both high.
- R9: `cmd_ready` is 1 only while no command is in progress, including just after reset. A command is taken on a clock edge with `cmd_valid` and `cmd_ready` both 1, and `rsp_done` is a pulse one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer can take a command |
| cmd_store | input | 1 | 1 = store, 0 = load |
| cmd_ref | input | 32 | Array reference |
| cmd_index | input | 32 | Element index (two's complement) |
| cmd_wval | input | 64 | Value to store |
| rsp_done | output | 1 | Completion pulse |
| rsp_err | output | 2 | 0 ok, 1 null reference, 2 index out of range |
| rsp_rdata | output | 64 | Loaded value (zero otherwise) |
| mem_rd | output | 1 | Read request strobe |
| mem_wr | output | 1 | Write request strobe |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid once busy is low |
| mem_busy | input | 1 | Memory busy, rises one cycle after a request |

## Verification
The bench tests an index equal to the length and an index of all ones. A design that checks only one bound would go on to touch memory for one of them, and the operation log would show extra transactions. It also tests the last legal index, where an off-by-one check would wrongly report status 2. The memory model drives garbage on the read data while it is busy, and it is run with busy delays of zero, one and several cycles. A sequencer that looked at busy in the cycle right after a request, or that overlapped requests, would return garbage or trip the model's overlap counter. Store-then-load round trips and the logged write data expose swapped halves or a wrong element stride.

// File: rtl/wes_pkg.sv
package wes_pkg;

  typedef enum logic [1:0] {
    ERR_NONE   = 2'd0,
    ERR_NULL   = 2'd1,
    ERR_BOUNDS = 2'd2
  } wes_err_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LEN,
    S_HDL,
    S_E0,
    S_E1
  } wes_state_e;

  typedef enum logic [1:0] {
    E_IDLE,
    E_ISSUE,
    E_LAG,
    E_WAIT
  } wes_eng_e;

endpackage

// File: rtl/wes_bound_chk.sv
module wes_bound_chk #(
  parameter int W = 32
) (
  input  logic [W-1:0] len,
  input  logic [W-1:0] idx,
  output logic         oob
);
  localparam int SIGN = W - 1;

  logic [W-1:0] room;
  logic [W-1:0] merged;

  always_comb begin
    room   = len - {{(W-1){1'b0}}, 1'b1} - idx;
    merged = room | idx;
    oob    = merged[SIGN];
  end
endmodule

// File: rtl/wes_mem_engine.sv
module wes_mem_engine
  import wes_pkg::*;
#(
  parameter int W        = 32,
  parameter int BUSY_LAG = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         start_wr,
  input  logic [W-1:0] start_addr,
  input  logic [W-1:0] start_wdata,
  output logic         idle,
  output logic         ack,
  output logic [W-1:0] ack_data,
  output logic         mem_rd,
  output logic         mem_wr,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  input  logic [W-1:0] mem_rdata,
  input  logic         mem_busy
);
  localparam int LAG_W = (BUSY_LAG < 2) ? 1 : $clog2(BUSY_LAG + 1);

  wes_eng_e   st;
  logic [LAG_W-1:0] lag_cnt;

  assign idle = (st == E_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= E_IDLE;
      lag_cnt   <= '0;
      ack       <= 1'b0;
      ack_data  <= '0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      ack <= 1'b0;
      case (st)
        E_IDLE: begin
          if (start) begin
            mem_rd    <= !start_wr;
            mem_wr    <= start_wr;
            mem_addr  <= start_addr;
            mem_wdata <= start_wdata;
            st        <= E_ISSUE;
          end
        end
        E_ISSUE: begin
          mem_rd  <= 1'b0;
          mem_wr  <= 1'b0;
          lag_cnt <= LAG_W'(BUSY_LAG);
          st      <= (BUSY_LAG == 0) ? E_WAIT : E_LAG;
        end
        E_LAG: begin
          if (lag_cnt <= LAG_W'(1)) st <= E_WAIT;
          lag_cnt <= lag_cnt - LAG_W'(1);
        end
        E_WAIT: begin
          if (!mem_busy) begin
            ack      <= 1'b1;
            ack_data <= mem_rdata;
            st       <= E_IDLE;
          end
        end
        default: st <= E_IDLE;
      endcase
    end
  end

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    start |-> idle); // R8
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || mem_wr) |=> !(mem_rd || mem_wr)); // R8
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_rd, mem_wr})); // R8
  AST_ACK_BUSY_LOW: assert property (@(posedge clk) disable iff (rst)
    ack |-> $past(!mem_busy)); // R8
endmodule

// File: rtl/wide_elem_seq.sv
module wide_elem_seq
  import wes_pkg::*;
#(
  parameter int W        = 32,
  parameter int BUSY_LAG = 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cmd_valid,
  output logic           cmd_ready,
  input  logic           cmd_store,
  input  logic [W-1:0]   cmd_ref,
  input  logic [W-1:0]   cmd_index,
  input  logic [2*W-1:0] cmd_wval,
  output logic           rsp_done,
  output logic [1:0]     rsp_err,
  output logic [2*W-1:0] rsp_rdata,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic [W-1:0]   mem_addr,
  output logic [W-1:0]   mem_wdata,
  input  logic [W-1:0]   mem_rdata,
  input  logic           mem_busy
);
  localparam int DW = 2 * W;
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  wes_state_e   st;
  logic         store_q;
  logic [W-1:0] ref_q;
  logic [W-1:0] idx_q;
  logic [DW-1:0] val_q;
  logic [W-1:0] elem_addr_q;
  logic [W-1:0] lo_q;

  logic         start;
  logic         start_wr;
  logic [W-1:0] start_addr;
  logic [W-1:0] start_wdata;
  logic         eng_idle;
  logic         ack;
  logic [W-1:0] ack_data;
  logic         oob;
  logic         cmd_fire;

  assign cmd_ready = (st == S_IDLE);
  assign cmd_fire  = cmd_valid && cmd_ready;

  wes_bound_chk #(.W(W)) u_bound (
    .len (ack_data),
    .idx (idx_q),
    .oob (oob)
  );

  wes_mem_engine #(.W(W), .BUSY_LAG(BUSY_LAG)) u_eng (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .start_wr    (start_wr),
    .start_addr  (start_addr),
    .start_wdata (start_wdata),
    .idle        (eng_idle),
    .ack         (ack),
    .ack_data    (ack_data),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_rdata   (mem_rdata),
    .mem_busy    (mem_busy)
  );

  always_comb begin
    start       = 1'b0;
    start_wr    = 1'b0;
    start_addr  = '0;
    start_wdata = '0;
    case (st)
      S_IDLE: begin
        if (cmd_fire && (cmd_ref != '0)) begin
          start      = 1'b1;
          start_addr = cmd_ref + ONE;
        end
      end
      S_LEN: begin
        if (ack && !oob) begin
          start      = 1'b1;
          start_addr = ref_q;
        end
      end
      S_HDL: begin
        if (ack) begin
          start       = 1'b1;
          start_wr    = store_q;
          start_addr  = ack_data + {idx_q[W-2:0], 1'b0};
          start_wdata = val_q[W-1:0];
        end
      end
      S_E0: begin
        if (ack) begin
          start       = 1'b1;
          start_wr    = store_q;
          start_addr  = elem_addr_q + ONE;
          start_wdata = val_q[DW-1:W];
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      store_q     <= 1'b0;
      ref_q       <= '0;
      idx_q       <= '0;
      val_q       <= '0;
      elem_addr_q <= '0;
      lo_q        <= '0;
      rsp_done    <= 1'b0;
      rsp_err     <= ERR_NONE;
      rsp_rdata   <= '0;
    end else begin
      rsp_done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (cmd_fire) begin
            store_q <= cmd_store;
            ref_q   <= cmd_ref;
            idx_q   <= cmd_index;
            val_q   <= cmd_wval;
            if (cmd_ref == '0) begin
              rsp_done  <= 1'b1;
              rsp_err   <= ERR_NULL;
              rsp_rdata <= '0;
            end else begin
              st <= S_LEN;
            end
          end
        end
        S_LEN: begin
          if (ack) begin
            if (oob) begin
              rsp_done  <= 1'b1;
              rsp_err   <= ERR_BOUNDS;
              rsp_rdata <= '0;
              st        <= S_IDLE;
            end else begin
              st <= S_HDL;
            end
          end
        end
        S_HDL: begin
          if (ack) begin
            elem_addr_q <= start_addr;
            st          <= S_E0;
          end
        end
        S_E0: begin
          if (ack) begin
            lo_q <= ack_data;
            st   <= S_E1;
          end
        end
        S_E1: begin
          if (ack) begin
            rsp_done  <= 1'b1;
            rsp_err   <= ERR_NONE;
            rsp_rdata <= store_q ? '0 : {ack_data, lo_q};
            st        <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_NULL_RESPONSE: assert property (@(posedge clk) disable iff (rst)
    (cmd_fire && cmd_ref == '0) |=> (rsp_done && rsp_err == ERR_NULL && !mem_rd && !mem_wr)); // R1
  AST_LEN_ADDR: assert property (@(posedge clk) disable iff (rst)
    (st == S_LEN && mem_rd) |-> (mem_addr == ref_q + ONE)); // R2
  AST_BOUNDS_STOP: assert property (@(posedge clk) disable iff (rst)
    (st == S_LEN && ack && oob) |=> (rsp_done && rsp_err == ERR_BOUNDS && st == S_IDLE && !mem_rd)); // R3
  AST_HANDLE_ADDR: assert property (@(posedge clk) disable iff (rst)
    (st == S_HDL && mem_rd) |-> (mem_addr == ref_q)); // R4
  AST_STORE_HIGH_SECOND: assert property (@(posedge clk) disable iff (rst)
    (st == S_E1 && mem_wr) |-> (mem_wdata == val_q[DW-1:W])); // R6
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
    cmd_fire |=> !(cmd_ready && mem_rd)); // R9
  AST_IDLE_ENGINE: assert property (@(posedge clk) disable iff (rst)
    (cmd_ready && !rsp_done) |-> eng_idle); // R9
endmodule

// File: tb/wide_elem_seq_tb_top.sv
module wide_elem_seq_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_store = 1'b0;
  logic [31:0] cmd_ref = '0;
  logic [31:0] cmd_index = '0;
  logic [63:0] cmd_wval = '0;
  logic        rsp_done;
  logic [1:0]  rsp_err;
  logic [63:0] rsp_rdata;
  logic        mem_rd, mem_wr;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata;
  logic        mem_busy;

  wide_elem_seq dut_i (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_store(cmd_store),
    .cmd_ref(cmd_ref), .cmd_index(cmd_index), .cmd_wval(cmd_wval),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_busy(mem_busy)
  );

  // behavioural memory with configurable busy delay
  logic [31:0] mem [0:255];
  int          dly = 2;
  logic        pend = 1'b0, pend_wr = 1'b0, busy = 1'b0;
  logic [31:0] pend_addr = '0, pend_wdata = '0, rdata = '0;
  int          cnt = 0;
  int          viol = 0;
  int          log_n = 0;
  logic        log_wr [0:255];
  logic [31:0] log_addr [0:255];
  logic [31:0] log_data [0:255];

  assign mem_busy  = busy;
  assign mem_rdata = rdata;

  always @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      busy <= 1'b0;
    end else begin
      if (pend) begin
        pend <= 1'b0;
        if (dly == 0) begin
          if (pend_wr) mem[pend_addr[7:0]] <= pend_wdata;
          else rdata <= mem[pend_addr[7:0]];
        end else begin
          busy  <= 1'b1;
          cnt   <= dly;
          rdata <= 32'hBAD0_BAD0;
        end
      end else if (busy) begin
        if (cnt == 1) begin
          busy <= 1'b0;
          if (pend_wr) mem[pend_addr[7:0]] <= pend_wdata;
          else rdata <= mem[pend_addr[7:0]];
        end
        cnt <= cnt - 1;
      end
      if (mem_rd || mem_wr) begin
        if (pend || busy) viol <= viol + 1;
        pend       <= 1'b1;
        pend_wr    <= mem_wr;
        pend_addr  <= mem_addr;
        pend_wdata <= mem_wdata;
        log_wr[log_n[7:0]]   <= mem_wr;
        log_addr[log_n[7:0]] <= mem_addr;
        log_data[log_n[7:0]] <= mem_wdata;
        log_n <= log_n + 1;
      end
    end
  end

  int tests = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  logic [1:0]  r_err;
  logic [63:0] r_data;
  logic        r_ready_after;

  task automatic run_cmd(input bit st, input logic [31:0] rf, input logic [31:0] ix, input logic [63:0] v);
    int n = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_store = st; cmd_ref = rf; cmd_index = ix; cmd_wval = v;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    r_ready_after = cmd_ready;
    while (!rsp_done && n < 2000) begin @(negedge clk); n++; end
    if (n >= 2000) chk(1'b0, "R8 timeout", 64'(n), 0);
    r_err  = rsp_err;
    r_data = rsp_rdata;
    @(posedge clk); #1;
    chk(!rsp_done, "R9 done pulse width", 64'(rsp_done), 0);
  endtask

  task automatic setup_array();
    mem[8'h10] = 32'h0000_0040;
    mem[8'h11] = 32'd5;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R9 ready after reset", 64'(cmd_ready), 1);
    chk(rsp_done == 1'b0, "R9 no done after reset", 64'(rsp_done), 0);
    chk(log_n == 0, "R9 no memory op after reset", 64'(log_n), 0);
  endtask

  task automatic t_null();
    int b = log_n;
    run_cmd(1'b1, 32'h0, 32'd1, 64'h1);
    chk(r_err == 2'd1, "R1 null status", 64'(r_err), 1);
    chk(log_n == b, "R1 no memory op", 64'(log_n - b), 0);
  endtask

  task automatic t_store_order();
    int b = log_n;
    run_cmd(1'b1, 32'h10, 32'd3, 64'h1122_3344_5566_7788);
    chk(r_err == 2'd0, "R6 store status", 64'(r_err), 0);
    chk(log_n - b == 4, "R6 op count", 64'(log_n - b), 4);
    chk(!log_wr[b[7:0]] && log_addr[b[7:0]] == 32'h11, "R2 length read first",
        64'(log_addr[b[7:0]]), 64'h11);
    chk(!log_wr[8'(b+1)] && log_addr[8'(b+1)] == 32'h10, "R4 handle read",
        64'(log_addr[8'(b+1)]), 64'h10);
    chk(log_wr[8'(b+2)] && log_addr[8'(b+2)] == 32'h46, "R5 first element addr",
        64'(log_addr[8'(b+2)]), 64'h46);
    chk(log_wr[8'(b+3)] && log_addr[8'(b+3)] == 32'h47, "R5 second element addr",
        64'(log_addr[8'(b+3)]), 64'h47);
    chk(log_data[8'(b+2)] == 32'h5566_7788, "R6 low word first", 64'(log_data[8'(b+2)]), 64'h5566_7788);
    chk(log_data[8'(b+3)] == 32'h1122_3344, "R6 high word second", 64'(log_data[8'(b+3)]), 64'h1122_3344);
  endtask

  task automatic t_load_back();
    int b = log_n;
    mem[8'h48] = 32'hCAFE_0001;
    mem[8'h49] = 32'hBEEF_0002;
    run_cmd(1'b0, 32'h10, 32'd4, 64'h0);
    chk(r_err == 2'd0, "R7 load status", 64'(r_err), 0);
    chk(r_data == 64'hBEEF_0002_CAFE_0001, "R7 load data", r_data, 64'hBEEF_0002_CAFE_0001);
    chk(log_addr[8'(b+2)] == 32'h48 && log_addr[8'(b+3)] == 32'h49, "R7 read order",
        64'(log_addr[8'(b+2)]), 64'h48);
    run_cmd(1'b0, 32'h10, 32'd3, 64'h0);
    chk(r_data == 64'h1122_3344_5566_7788, "R7 round trip", r_data, 64'h1122_3344_5566_7788);
  endtask

  task automatic t_bound_eq_len();
    int b = log_n;
    mem[8'h4A] = 32'h7777_7777;
    run_cmd(1'b1, 32'h10, 32'd5, 64'hFFFF_FFFF_FFFF_FFFF);
    chk(r_err == 2'd2, "R3 index equal length", 64'(r_err), 2);
    chk(log_n - b == 1, "R3 only length read", 64'(log_n - b), 1);
    chk(mem[8'h4A] == 32'h7777_7777, "R3 no element write", 64'(mem[8'h4A]), 64'h7777_7777);
  endtask

  task automatic t_neg_index();
    int b = log_n;
    run_cmd(1'b0, 32'h10, 32'hFFFF_FFFF, 64'h0);
    chk(r_err == 2'd2, "R3 negative index", 64'(r_err), 2);
    chk(log_n - b == 1, "R3 negative index only length read", 64'(log_n - b), 1);
    run_cmd(1'b0, 32'h10, 32'h8000_0000, 64'h0);
    chk(r_err == 2'd2, "R3 most negative index", 64'(r_err), 2);
  endtask

  task automatic t_delays();
    for (int d = 0; d < 4; d++) begin
      logic [63:0] v;
      dly = (d == 3) ? 7 : d;
      v = {32'hA000_0000 | 32'(d), 32'h0B00_0000 | 32'(d)};
      run_cmd(1'b1, 32'h10, 32'd0, v);
      run_cmd(1'b0, 32'h10, 32'd0, 64'h0);
      chk(r_data == v && r_err == 2'd0, "R8 round trip under busy delay", r_data, v);
    end
    chk(viol == 0, "R8 no overlapping requests", 64'(viol), 0);
    dly = 2;
  endtask

  task automatic t_handshake();
    run_cmd(1'b0, 32'h10, 32'd1, 64'h0);
    chk(r_ready_after == 1'b0, "R9 ready low while busy", 64'(r_ready_after), 0);
    run_cmd(1'b0, 32'h0, 32'd1, 64'h0);
    chk(r_ready_after == 1'b1, "R9 ready back after null", 64'(r_ready_after), 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    setup_array();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_null();
    t_store_order();
    t_load_back();
    t_bound_eq_len();
    t_neg_index();
    t_delays();
    t_handshake();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule